// File: doc/BRIEF.md
# Synthesizer Channel Divider Controller

This block turns a channel request into the two divider words an external frequency synthesizer needs, then delivers them over a three-wire link made of a data line, a clock line and a latch strobe. The request carries the channel frequency, a transmit/receive flag and a channel-step code. The block chooses the reference divider from the step code, which also fixes the comparison frequency at 5 kHz or 6.25 kHz. It then computes the main divider N from the frequency the oscillator must produce. In receive, that frequency lies one first-IF offset (21.7 MHz) below the channel frequency. In transmit, it is the channel frequency itself.

A controller places the request on the inputs and pulses `load_req_i` while `done_o` is high. The block drives a range-select line that switches the oscillator band. This line uses one threshold for transmit and a different one for receive. A request whose oscillator frequency does not fall exactly on the comparison grid is refused. When that happens the error flag is raised and nothing is sent.

Frequencies are given in units of 1.25 kHz, the finest grain shared by both comparison frequencies. On this scale 5 kHz is 4 units, 6.25 kHz is 5 units and the IF offset is 17360 units.

Top module: `chan_synth_ctrl`

## Requirements
- R1: The reference word is 3400 when the step code is 2 (12.5 kHz, 6.25 kHz comparison). It is 4250 for every other step code (0=5, 1=10, 3=15, 4=20, 5=25, 6=30, 7=50 kHz).
- R2: In transmit (`tx_i`=1), N equals `freq_i` divided by the comparison size in 1.25 kHz units: 4 for 5 kHz, 5 for 6.25 kHz.
- R3: In receive (`tx_i`=0), N equals (`freq_i` − 17360) divided by the comparison size.
- R4: In transmit, `vco_hi_o` is 1 when `freq_i` ≥ 112000 (140.000 MHz) and 0 below that value.
- R5: In receive, `vco_hi_o` is 1 when `freq_i` ≥ 129360 (161.700 MHz) and 0 below that value.
- R6: A transfer is 29 bits. The 13-bit reference word comes first and the 16-bit N word follows, each MSB first. The data line changes only while `sclk_o` is low, so each bit is valid at the rising edge of `sclk_o`.
- R7: After the last bit, `strb_o` is high for exactly one bit period (4 clock cycles by default) while `sclk_o` stays low. `done_o` returns high in the cycle the strobe falls.
- R8: If the oscillator frequency is not a whole multiple of the comparison size, the request sets `err_o`. In that case no clock or strobe activity occurs and `vco_hi_o` keeps its previous value. The next accepted request clears `err_o`.
- R9: A `load_req_i` that arrives while `done_o` is low is ignored. The running transfer keeps its words, `err_o` and `vco_hi_o` do not change, and no second transfer follows.
- R10: After reset, `done_o`=1 and `sclk_o`, `sdata_o`, `strb_o`, `err_o` and `vco_hi_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req_i | input | 1 | Load request, sampled while done is high |
| freq_i | input | 18 | Channel frequency in 1.25 kHz units |
| tx_i | input | 1 | 1 = transmit, 0 = receive |
| step_i | input | 3 | Channel-step code |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data to the synthesizer |
| strb_o | output | 1 | Latch strobe |
| vco_hi_o | output | 1 | Oscillator band select |
| done_o | output | 1 | Idle / transfer complete |
| err_o | output | 1 | Last request was off the comparison grid |

## Verification
The bench probes both band thresholds at the last channel below each threshold and at the first channel on it. A design that compared against the wrong threshold, or used the receive threshold in transmit, would show the wrong band on one of those pairs. Off-grid requests are applied for each comparison size and for receive after the IF offset is removed. A design that tested the remainder before subtracting the offset, or that still shifted the refused word out, would show clock edges or a cleared error flag. A second request sent in the middle of a transfer must not alter the captured words or start another frame. The strobe width and the word order are measured from the serial lines themselves, so swapped words or a short latch pulse show up directly.

// File: rtl/chsyn_pkg.sv
package chsyn_pkg;

    typedef enum logic [2:0] {
        STEP_5K   = 3'd0,
        STEP_10K  = 3'd1,
        STEP_12K5 = 3'd2,
        STEP_15K  = 3'd3,
        STEP_20K  = 3'd4,
        STEP_25K  = 3'd5,
        STEP_30K  = 3'd6,
        STEP_50K  = 3'd7
    } step_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_DATA  = 2'd1,
        SH_LATCH = 2'd2
    } sh_state_e;

    // comparison sizes in 1.25 kHz units
    localparam int unsigned CMP_UNITS_COARSE = 4;  // 5 kHz
    localparam int unsigned CMP_UNITS_FINE   = 5;  // 6.25 kHz

    // only the 12.5 kHz step runs on the 6.25 kHz comparison
    function automatic logic uses_fine_cmp(input step_e s);
        return (s == STEP_12K5);
    endfunction

endpackage

// File: rtl/chsyn_calc.sv
module chsyn_calc
    import chsyn_pkg::*;
#(
    parameter int unsigned FREQ_W    = 18,
    parameter int unsigned R_W       = 13,
    parameter int unsigned N_W       = 16,
    parameter int unsigned IF_UNITS  = 17360,
    parameter int unsigned TX_SPLIT  = 112000,
    parameter int unsigned RX_SPLIT  = 129360,
    parameter int unsigned REF_COARSE = 4250,
    parameter int unsigned REF_FINE   = 3400
) (
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              tx_i,
    input  logic [2:0]        step_i,
    output logic [R_W-1:0]    r_word_o,
    output logic [N_W-1:0]    n_word_o,
    output logic              vco_hi_o,
    output logic              off_grid_o
);

    logic              fine;
    logic [FREQ_W-1:0] osc_units;
    logic [FREQ_W-1:0] cmp_units;
    logic [2:0]        rem;

    always_comb begin
        fine      = uses_fine_cmp(step_e'(step_i));
        osc_units = tx_i ? freq_i : (freq_i - FREQ_W'(IF_UNITS));
        cmp_units = fine ? FREQ_W'(CMP_UNITS_FINE) : FREQ_W'(CMP_UNITS_COARSE);
        rem       = 3'(osc_units % cmp_units);
        n_word_o  = N_W'(osc_units / cmp_units);
        off_grid_o = (rem != 3'd0);
        r_word_o  = fine ? R_W'(REF_FINE) : R_W'(REF_COARSE);
        if (tx_i)
            vco_hi_o = (freq_i >= FREQ_W'(TX_SPLIT));
        else
            vco_hi_o = (freq_i >= FREQ_W'(RX_SPLIT));
    end

endmodule

// File: rtl/chsyn_pace.sv
module chsyn_pace #(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned CW = $clog2(HALF_CYC) + 1;

    logic [CW-1:0] cnt;

    assign tick_o = run_i && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/chsyn_shift.sv
module chsyn_shift
    import chsyn_pkg::*;
#(
    parameter int unsigned W        = 29,
    parameter int unsigned HALF_CYC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] word_i,
    output logic         busy_o,
    output logic         sclk_o,
    output logic         sdata_o,
    output logic         strb_o
);

    localparam int unsigned IW = $clog2(W);

    sh_state_e     state;
    logic [W-1:0]  shreg;
    logic [IW-1:0] idx;
    logic          ph;
    logic          tick;

    chsyn_pace #(.HALF_CYC(HALF_CYC)) u_pace (
        .clk   (clk),
        .rst   (rst),
        .run_i (state != SH_IDLE),
        .tick_o(tick)
    );

    assign busy_o  = (state != SH_IDLE);
    assign sdata_o = (state == SH_DATA) && shreg[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            shreg  <= '0;
            idx    <= '0;
            ph     <= 1'b0;
            sclk_o <= 1'b0;
            strb_o <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    if (start_i) begin
                        shreg  <= word_i;
                        idx    <= IW'(W - 1);
                        ph     <= 1'b0;
                        sclk_o <= 1'b0;
                        state  <= SH_DATA;
                    end
                end
                SH_DATA: begin
                    if (tick) begin
                        if (!ph) begin
                            sclk_o <= 1'b1;
                            ph     <= 1'b1;
                        end else begin
                            sclk_o <= 1'b0;
                            ph     <= 1'b0;
                            if (idx == '0) begin
                                state  <= SH_LATCH;
                                strb_o <= 1'b1;
                            end else begin
                                shreg <= shreg << 1;
                                idx   <= idx - 1'b1;
                            end
                        end
                    end
                end
                SH_LATCH: begin
                    if (tick) begin
                        if (!ph) begin
                            ph <= 1'b1;
                        end else begin
                            ph     <= 1'b0;
                            strb_o <= 1'b0;
                            state  <= SH_IDLE;
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // R6
    data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> $stable(sdata_o));

    // R7
    latch_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        strb_o |-> !sclk_o);

    // R7
    strobe_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strb_o) |-> $fell(sclk_o));

endmodule

// File: rtl/chan_synth_ctrl.sv
module chan_synth_ctrl
    import chsyn_pkg::*;
#(
    parameter int unsigned FREQ_W     = 18,
    parameter int unsigned R_W        = 13,
    parameter int unsigned HALF_CYC   = 2,
    parameter int unsigned IF_UNITS   = 17360,
    parameter int unsigned TX_SPLIT   = 112000,
    parameter int unsigned RX_SPLIT   = 129360,
    parameter int unsigned REF_COARSE = 4250,
    parameter int unsigned REF_FINE   = 3400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              tx_i,
    input  logic [2:0]        step_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              strb_o,
    output logic              vco_hi_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int unsigned N_W     = FREQ_W - 2;
    localparam int unsigned FRAME_W = R_W + N_W;

    logic [R_W-1:0] r_word;
    logic [N_W-1:0] n_word;
    logic           vco_next;
    logic           off_grid;
    logic           busy;
    logic           accept;
    logic           start;

    chsyn_calc #(
        .FREQ_W    (FREQ_W),
        .R_W       (R_W),
        .N_W       (N_W),
        .IF_UNITS  (IF_UNITS),
        .TX_SPLIT  (TX_SPLIT),
        .RX_SPLIT  (RX_SPLIT),
        .REF_COARSE(REF_COARSE),
        .REF_FINE  (REF_FINE)
    ) u_calc (
        .freq_i    (freq_i),
        .tx_i      (tx_i),
        .step_i    (step_i),
        .r_word_o  (r_word),
        .n_word_o  (n_word),
        .vco_hi_o  (vco_next),
        .off_grid_o(off_grid)
    );

    assign accept = load_req_i && !busy;
    assign start  = accept && !off_grid;
    assign done_o = !busy;

    chsyn_shift #(
        .W       (FRAME_W),
        .HALF_CYC(HALF_CYC)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .word_i ({r_word, n_word}),
        .busy_o (busy),
        .sclk_o (sclk_o),
        .sdata_o(sdata_o),
        .strb_o (strb_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o    <= 1'b0;
            vco_hi_o <= 1'b0;
        end else if (accept) begin
            err_o <= off_grid;
            if (!off_grid)
                vco_hi_o <= vco_next;
        end
    end

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $fell(strb_o));

    // R8
    reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (done_o && !strb_o));

    // R9
    vco_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> $stable(vco_hi_o));

endmodule

// File: tb/sim_chan_synth_ctrl.sv
`timescale 1ns/1ps
module sim_chan_synth_ctrl;

    typedef struct packed {
        logic [17:0] f;
        logic        tx;
        logic [2:0]  st;
        logic [12:0] r;
        logic [15:0] n;
        logic        v;
        logic        e;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{18'd117216, 1'b1, 3'd0, 13'd4250, 16'd29304, 1'b1, 1'b0},
        '{18'd111996, 1'b1, 3'd0, 13'd4250, 16'd27999, 1'b0, 1'b0},
        '{18'd112000, 1'b1, 3'd0, 13'd4250, 16'd28000, 1'b1, 1'b0},
        '{18'd117217, 1'b1, 3'd0, 13'd0,    16'd0,     1'b1, 1'b1},
        '{18'd117216, 1'b0, 3'd0, 13'd4250, 16'd24964, 1'b0, 1'b0},
        '{18'd129356, 1'b0, 3'd0, 13'd4250, 16'd27999, 1'b0, 1'b0},
        '{18'd129360, 1'b0, 3'd0, 13'd4250, 16'd28000, 1'b1, 1'b0},
        '{18'd129361, 1'b0, 3'd0, 13'd0,    16'd0,     1'b1, 1'b1},
        '{18'd117210, 1'b1, 3'd2, 13'd3400, 16'd23442, 1'b1, 1'b0},
        '{18'd116010, 1'b0, 3'd2, 13'd3400, 16'd19730, 1'b0, 1'b0},
        '{18'd117216, 1'b1, 3'd2, 13'd0,    16'd0,     1'b0, 1'b1},
        '{18'd139196, 1'b1, 3'd0, 13'd4250, 16'd34799, 1'b1, 1'b0},
        '{18'd120000, 1'b1, 3'd7, 13'd4250, 16'd30000, 1'b1, 1'b0},
        '{18'd129360, 1'b0, 3'd5, 13'd4250, 16'd28000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_req = 1'b0;
    logic [17:0] freq = '0;
    logic        tx = 1'b0;
    logic [2:0]  step = '0;
    logic        sclk, sdata, strb, vco, done, err;

    int checks = 0;
    int fails  = 0;
    int ncap   = 0;
    int strbcnt = 0;
    logic [28:0] cap = '0;

    always #2.5 clk = ~clk;

    chan_synth_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .load_req_i(load_req),
        .freq_i    (freq),
        .tx_i      (tx),
        .step_i    (step),
        .sclk_o    (sclk),
        .sdata_o   (sdata),
        .strb_o    (strb),
        .vco_hi_o  (vco),
        .done_o    (done),
        .err_o     (err)
    );

    always @(posedge sclk) begin
        cap  = {cap[27:0], sdata};
        ncap = ncap + 1;
    end

    always @(negedge clk) begin
        if (strb) strbcnt = strbcnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [17:0] f, input logic t, input logic [2:0] s);
        @(negedge clk);
        ncap = 0;
        strbcnt = 0;
        freq = f;
        tx = t;
        step = s;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (!done && k < 1000) begin
            @(negedge clk);
            k++;
        end
        if (!done) check("watch", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 done", int'(done), 1);
        check("R10 sclk", int'(sclk), 0);
        check("R10 strb", int'(strb), 0);
        check("R10 sdata", int'(sdata), 0);
        check("R10 err", int'(err), 0);
        check("R10 vco", int'(vco), 0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].f, VECS[i].tx, VECS[i].st);
            if (VECS[i].e) begin
                repeat (3) @(negedge clk);
                // R8 off-grid refused
                check("R8 err", int'(err), 1);
                check("R8 done", int'(done), 1);
                check("R8 bits", ncap, 0);
                check("R8 strobe", strbcnt, 0);
                check("R8 vco held", int'(vco), int'(VECS[i].v));
            end else begin
                wait_done();
                check("R1 ref word", int'(cap[28:16]), int'(VECS[i].r));
                if (VECS[i].tx)
                    check("R2 tx N", int'(cap[15:0]), int'(VECS[i].n));
                else
                    check("R3 rx N", int'(cap[15:0]), int'(VECS[i].n));
                check("R6 bit count", ncap, 29);
                check("R7 strobe width", strbcnt, 4);
                if (VECS[i].tx)
                    check("R4 tx band", int'(vco), int'(VECS[i].v));
                else
                    check("R5 rx band", int'(vco), int'(VECS[i].v));
                check("R8 err clear", int'(err), 0);
            end
        end

        // R9 request during a transfer is ignored
        issue(18'd117216, 1'b1, 3'd0);
        repeat (20) @(negedge clk);
        check("R9 busy", int'(done), 0);
        freq = 18'd117217;
        tx = 1'b0;
        step = 3'd2;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        wait_done();
        check("R9 ref kept", int'(cap[28:16]), 4250);
        check("R9 N kept", int'(cap[15:0]), 29304);
        check("R9 err untouched", int'(err), 0);
        check("R9 vco untouched", int'(vco), 1);
        repeat (60) @(negedge clk);
        check("R9 no second frame", ncap, 29);
        check("R9 idle", int'(done), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule